// File: doc/BRIEF.md
# Serial EEPROM Command Front End

This block is the slave side of a four-wire serial link to a small byte-addressed nonvolatile memory. It oversamples the serial clock, chip select, data-in and pause inputs on the system clock. It decodes a one-byte instruction and gathers a two-byte address. For a read, it streams bytes from the array read port and steps the address after each byte, so one transfer can sweep the whole array. For a status read, it streams the status byte supplied by a neighbouring unit.

Write data, status-register writes and the two write-latch commands are not acted on here. They are handed to a separate write controller and protection unit as single-cycle strobes, each carrying a byte and, for array data, its target address. That unit reports a running programming cycle on `busy`. While `busy` is high, the engine honours only the status read.

The data-out pin is modelled as a value plus an enable. The enable is low whenever nothing is being driven.

Top module: `spi_eeprom_cmd`

## Requirements
- R1: After reset, and while chip select is high, `so_en` is low and no strobe is issued. Every transaction starts on a falling chip select.
- R2: The first byte is decoded MSB first with bit 3 ignored. 0x06/0x0E pulse `wren_pulse`, 0x04/0x0C pulse `wrdi_pulse`, 0x05/0x0D start a status read, 0x01/0x09 start a status write, 0x03/0x0B start a read, and 0x02/0x0A start an array write.
- R3: Any other first byte, including one with a nonzero upper nibble, makes the engine ignore all further input with `so_en` low until chip select falls again.
- R4: A read takes 16 address bits MSB first and keeps only the low ADDR_BITS. It then ignores `si` and drives the addressed byte MSB first. `so` changes only after falling SCK, so it is stable when rising SCK samples it.
- R5: During a read, the address advances by one after each byte and wraps from the top address to 0.
- R6: A status read returns `stat_in`, MSB first, and repeats it for as long as clocking continues.
- R7: During an array write, each completed data byte gives one `wbyte_wr` pulse with `wr_byte` and `wr_addr`. Only the low PAGE_BITS of the address advance between bytes; the upper bits stay fixed.
- R8: A status write issues exactly one `stat_wr` pulse carrying the first data byte. Later bytes are ignored.
- R9: While `busy` is high at decode time, every instruction except the status read is ignored.
- R10: The pause input (`hold_n`) works as follows. Taking `hold_n` low while SCK is low freezes the sequence, forces `so_en` low and ignores SCK and `si`. Raising `hold_n` while SCK is low resumes from the same bit.
- R11: Clock mode 0 (SCK idle low) and clock mode 3 (SCK idle high) give identical results.
- R12: Raising chip select part way through a byte discards that byte with no strobe. The next transaction decodes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause input, active low |
| busy | input | 1 | Write controller programming cycle in progress |
| stat_in | input | 8 | Status byte to return on a status read |
| rd_data | input | 8 | Array byte at `rd_addr` |
| so | output | 1 | Serial data out value |
| so_en | output | 1 | Serial data out enable (low means high impedance) |
| rd_addr | output | ADDR_BITS | Array read address |
| wr_addr | output | ADDR_BITS | Address of the byte on a `wbyte_wr` strobe |
| wr_byte | output | 8 | Data byte for `wbyte_wr` or `stat_wr` |
| wren_pulse | output | 1 | Set-write-latch strobe |
| wrdi_pulse | output | 1 | Clear-write-latch strobe |
| stat_wr | output | 1 | Status write strobe |
| wbyte_wr | output | 1 | Array data byte strobe |

## Verification
The hardest state to reach is a pause in the middle of a byte. Here `hold_n` must drop only after a falling SCK edge has already pushed the next read bit out. Extra SCK pulses with garbage on `si` must then have no effect, and after resume the bench must sample the bit that was pending rather than a shifted one. The bench reaches this state by driving the serial pins bit by bit. It splits one read byte and one write byte into two nibbles, pauses between them, and compares the reassembled bytes and the following byte with the array model. Address wrap is reached by starting a read two bytes below the top of the array.

// File: rtl/spi_eeprom_cmd.sv
module spi_eeprom_cmd #(
  parameter int ADDR_BITS = 10,
  parameter int PAGE_BITS = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 sck,
  input  logic                 si,
  input  logic                 hold_n,
  input  logic                 busy,
  input  logic [7:0]           stat_in,
  input  logic [7:0]           rd_data,
  output logic                 so,
  output logic                 so_en,
  output logic [ADDR_BITS-1:0] rd_addr,
  output logic [ADDR_BITS-1:0] wr_addr,
  output logic [7:0]           wr_byte,
  output logic                 wren_pulse,
  output logic                 wrdi_pulse,
  output logic                 stat_wr,
  output logic                 wbyte_wr
);

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_ADDR, S_RDAT, S_STAT, S_WDAT, S_WSR, S_MUTE
  } st_t;

  localparam logic [ADDR_BITS-1:0] A_ONE = 1;
  localparam logic [PAGE_BITS-1:0] P_ONE = 1;

  st_t                 st;
  logic                sck_r, sck_p, cs_r, cs_p, si_r, hold_r;
  logic                held, drv, is_wr, so_q;
  logic [3:0]          cnt;
  logic [6:0]          sh, obuf;
  logic [ADDR_BITS-1:0] addr;
  logic [7:0]          nb, obyte;
  logic                rise, fall, out_st;

  assign rise   = sck_r & ~sck_p;
  assign fall   = ~sck_r & sck_p;
  assign nb     = {sh, si_r};
  assign obyte  = (st == S_RDAT) ? rd_data : stat_in;
  assign out_st = (st == S_RDAT) || (st == S_STAT);
  assign so     = so_q;
  assign so_en  = drv && !held && out_st;
  assign rd_addr = addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      {sck_r, sck_p, si_r} <= '0;
      {cs_r, cs_p, hold_r} <= '1;
      {held, drv, is_wr, so_q} <= '0;
      cnt <= '0; sh <= '0; obuf <= '0; addr <= '0;
      wr_addr <= '0; wr_byte <= '0;
      {wren_pulse, wrdi_pulse, stat_wr, wbyte_wr} <= '0;
    end else begin
      sck_r <= sck; sck_p <= sck_r; si_r <= si;
      cs_r <= cs_n; cs_p <= cs_r; hold_r <= hold_n;
      {wren_pulse, wrdi_pulse, stat_wr, wbyte_wr} <= '0;
      if (cs_r) begin
        st <= S_IDLE; held <= 1'b0; drv <= 1'b0;
      end else if (cs_p) begin
        st <= S_CMD; cnt <= '0; held <= 1'b0; drv <= 1'b0;
      end else if (held) begin
        if (hold_r && !sck_r) held <= 1'b0;
      end else if (!hold_r && !sck_r && st != S_IDLE) begin
        held <= 1'b1;
      end else if (rise) begin
        if (!out_st) begin
          cnt <= cnt + 4'd1;
          sh  <= nb[6:0];
        end
        case (st)
          S_CMD: if (cnt == 4'd7) begin
            cnt <= '0;
            if (nb[7:4] != 4'd0 || (busy && nb[2:0] != 3'b101)) st <= S_MUTE;
            else case (nb[2:0])
              3'b110: begin wren_pulse <= 1'b1; st <= S_MUTE; end
              3'b100: begin wrdi_pulse <= 1'b1; st <= S_MUTE; end
              3'b101: st <= S_STAT;
              3'b001: st <= S_WSR;
              3'b011: begin st <= S_ADDR; is_wr <= 1'b0; end
              3'b010: begin st <= S_ADDR; is_wr <= 1'b1; end
              default: st <= S_MUTE;
            endcase
          end
          S_ADDR: begin
            addr <= {addr[ADDR_BITS-2:0], si_r};
            if (cnt == 4'd15) begin
              cnt <= '0;
              st  <= is_wr ? S_WDAT : S_RDAT;
            end
          end
          S_WDAT: if (cnt == 4'd7) begin
            cnt <= '0;
            wbyte_wr <= 1'b1; wr_byte <= nb; wr_addr <= addr;
            addr <= {addr[ADDR_BITS-1:PAGE_BITS], addr[PAGE_BITS-1:0] + P_ONE};
          end
          S_WSR: if (cnt == 4'd7) begin
            stat_wr <= 1'b1; wr_byte <= nb; st <= S_MUTE;
          end
          default: ;
        endcase
      end else if (fall && out_st) begin
        cnt <= {1'b0, cnt[2:0] + 3'd1};
        if (cnt[2:0] == 3'd0) begin
          so_q <= obyte[7];
          obuf <= obyte[6:0];
          drv  <= 1'b1;
          if (st == S_RDAT) addr <= addr + A_ONE;
        end else begin
          so_q <= obuf[6];
          obuf <= {obuf[5:0], 1'b0};
        end
      end
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_r && $past(cs_r)) |-> (!so_en && !wren_pulse && !wrdi_pulse && !stat_wr && !wbyte_wr));

  // R9
  busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wren_pulse || wrdi_pulse) |-> !$past(busy));

  // R5
  read_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RDAT && $past(st) == S_RDAT) |->
      (rd_addr == $past(rd_addr) || rd_addr == ($past(rd_addr) + A_ONE)));

  // R10
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held && $past(held)) |-> ($stable(rd_addr) && $stable(so) && !so_en));

  // R7
  page_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wbyte_wr |-> (wr_addr[ADDR_BITS-1:PAGE_BITS] == rd_addr[ADDR_BITS-1:PAGE_BITS]));

endmodule

// File: tb/spi_eeprom_cmd_bench.sv
module spi_eeprom_cmd_bench;
  localparam int AW = 10;
  localparam int HALF = 5;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic hold_n = 1'b1, busy = 1'b0;
  logic [7:0] stat_in = 8'h00;
  logic [7:0] rd_data, wr_byte;
  logic so, so_en, wren_pulse, wrdi_pulse, stat_wr, wbyte_wr;
  logic [AW-1:0] rd_addr, wr_addr;

  int n_cmp = 0, n_bad = 0, done = 0;
  int n_wren = 0, n_wrdi = 0, n_sr = 0, n_wb = 0;
  logic [7:0] last_sr = 8'h00;
  logic [AW-1:0] cap_a [16];
  logic [7:0] cap_d [16];
  logic m3 = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [7:0] model(input logic [AW-1:0] a);
    return 8'(a * 37 + 5) ^ 8'(a >> 2);
  endfunction

  assign rd_data = model(rd_addr);

  spi_eeprom_cmd #(.ADDR_BITS(AW), .PAGE_BITS(5)) u_spi_eeprom_cmd (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .busy(busy), .stat_in(stat_in), .rd_data(rd_data), .so(so), .so_en(so_en),
    .rd_addr(rd_addr), .wr_addr(wr_addr), .wr_byte(wr_byte),
    .wren_pulse(wren_pulse), .wrdi_pulse(wrdi_pulse), .stat_wr(stat_wr), .wbyte_wr(wbyte_wr));

  always @(posedge clk) begin
    if (wren_pulse) n_wren++;
    if (wrdi_pulse) n_wrdi++;
    if (stat_wr) begin n_sr++; last_sr = wr_byte; end
    if (wbyte_wr) begin
      cap_a[n_wb[3:0]] = wr_addr;
      cap_d[n_wb[3:0]] = wr_byte;
      n_wb++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start();
    @(negedge clk);
    sck = m3; wt(HALF);
    cs_n = 1'b0; wt(HALF);
  endtask

  task automatic stop();
    if (!m3) sck = 1'b0;
    wt(HALF);
    cs_n = 1'b1; wt(2 * HALF);
  endtask

  task automatic bit_io(input logic v, output logic o, output logic e);
    sck = 1'b0; si = v; wt(HALF);
    o = so; e = so_en;
    sck = 1'b1; wt(HALF);
  endtask

  task automatic byte_io(input logic [7:0] tx, output logic [7:0] rx, output int en);
    logic b, e;
    en = 0;
    for (int i = 7; i >= 0; i--) begin
      bit_io(tx[i], b, e);
      rx[i] = b;
      en += int'(e);
    end
  endtask

  task automatic send(input logic [7:0] tx);
    logic [7:0] rx; int en;
    byte_io(tx, rx, en);
  endtask

  task automatic t_reset();
    chk("R1 so_en after reset", so_en, 0);
    chk("R1 no strobes after reset", n_wren + n_wrdi + n_sr + n_wb, 0);
  endtask

  task automatic t_opcodes();
    start(); send(8'h06); stop();
    chk("R2 wren 0x06", n_wren, 1);
    start(); send(8'h0E); stop();
    chk("R2 wren 0x0E bit3 ignored", n_wren, 2);
    start(); send(8'h04); stop();
    start(); send(8'h0C); stop();
    chk("R2 wrdi 0x04/0x0C", n_wrdi, 2);
  endtask

  task automatic t_invalid();
    logic [7:0] rx; int en;
    start(); send(8'h07); byte_io(8'h06, rx, en); stop();
    chk("R3 invalid then wren ignored", n_wren, 2);
    chk("R3 so_en stays low", en, 0);
    start(); send(8'h46); stop();
    chk("R3 upper nibble nonzero", n_wren, 2);
    start(); send(8'h06); stop();
    chk("R3 recovers on new select", n_wren, 3);
  endtask

  task automatic t_read(input logic mode, input logic [7:0] op, input logic [15:0] a, input int nbytes);
    logic [7:0] rx; int en;
    logic [AW-1:0] exp_a;
    m3 = mode;
    exp_a = a[AW-1:0];
    start();
    byte_io(op, rx, en);
    chk("R4 no drive during command", en, 0);
    send(a[15:8]); send(a[7:0]);
    for (int k = 0; k < nbytes; k++) begin
      byte_io(8'hFF, rx, en);
      chk(mode ? "R11 R4 R5 mode3 read byte" : "R4 R5 mode0 read byte", rx, model(exp_a));
      chk("R4 so_en during data", en, 8);
      exp_a = exp_a + AW'(1);
    end
    stop();
    chk("R1 released after read", so_en, 0);
    m3 = 1'b0;
  endtask

  task automatic t_rdsr();
    logic [7:0] rx; int en;
    stat_in = 8'hA5;
    start(); send(8'h05);
    byte_io(8'h00, rx, en); chk("R6 status byte", rx, 8'hA5);
    byte_io(8'h00, rx, en); chk("R6 status repeats", rx, 8'hA5);
    stop();
    stat_in = 8'h00;
  endtask

  task automatic t_write();
    int base;
    logic [7:0] d [4];
    d[0] = 8'h11; d[1] = 8'h22; d[2] = 8'h33; d[3] = 8'h44;
    base = n_wb;
    start(); send(8'h02); send(8'hF0); send(8'h1E);
    for (int k = 0; k < 4; k++) send(d[k]);
    stop();
    chk("R7 write strobe count", n_wb - base, 4);
    chk("R7 addr 0", cap_a[(base + 0) % 16], 10'h01E);
    chk("R7 addr 1", cap_a[(base + 1) % 16], 10'h01F);
    chk("R7 page wrap addr", cap_a[(base + 2) % 16], 10'h000);
    chk("R7 addr 3", cap_a[(base + 3) % 16], 10'h001);
    chk("R7 data 2", cap_d[(base + 2) % 16], 8'h33);
  endtask

  task automatic t_wrsr();
    int base;
    base = n_sr;
    start(); send(8'h09); send(8'h8C); send(8'h55); stop();
    chk("R8 one status write", n_sr - base, 1);
    chk("R8 status byte", last_sr, 8'h8C);
  endtask

  task automatic t_busy();
    logic [7:0] rx; int en;
    int w0;
    w0 = n_wren;
    busy = 1'b1;
    start(); send(8'h06); stop();
    chk("R9 wren ignored when busy", n_wren, w0);
    start(); send(8'h03); send(8'h00); send(8'h10);
    byte_io(8'h00, rx, en); stop();
    chk("R9 read ignored when busy", en, 0);
    stat_in = 8'hFF;
    start(); send(8'h05); byte_io(8'h00, rx, en); stop();
    chk("R9 status read while busy", rx, 8'hFF);
    chk("R9 status drive while busy", en, 8);
    busy = 1'b0; stat_in = 8'h00;
  endtask

  task automatic pause_and_resume();
    sck = 1'b0; wt(HALF);
    hold_n = 1'b0; wt(HALF);
    chk("R10 so floats in pause", so_en, 0);
    for (int j = 0; j < 3; j++) begin
      si = ~si; sck = 1'b1; wt(HALF);
      sck = 1'b0; wt(HALF);
    end
    chk("R10 still floating", so_en, 0);
    hold_n = 1'b1; wt(HALF);
  endtask

  task automatic t_hold();
    logic [7:0] rx, full; int en;
    logic b, e;
    int base;
    start(); send(8'h03); send(8'h00); send(8'h40);
    for (int i = 7; i >= 4; i--) begin bit_io(1'b0, b, e); full[i] = b; end
    pause_and_resume();
    for (int i = 3; i >= 0; i--) begin bit_io(1'b0, b, e); full[i] = b; end
    chk("R10 read byte across pause", full, model(10'h040));
    byte_io(8'h00, rx, en);
    chk("R10 next byte after pause", rx, model(10'h041));
    stop();
    base = n_wb;
    start(); send(8'h02); send(8'h01); send(8'h00);
    for (int i = 7; i >= 4; i--) bit_io(((8'hA6 >> i) & 8'h01) != 0, b, e);
    pause_and_resume();
    for (int i = 3; i >= 0; i--) bit_io(((8'hA6 >> i) & 8'h01) != 0, b, e);
    stop();
    chk("R10 one write byte", n_wb - base, 1);
    chk("R10 si ignored in pause", cap_d[base % 16], 8'hA6);
    chk("R10 write addr", cap_a[base % 16], 10'h100);
  endtask

  task automatic t_abort();
    logic b, e;
    int wb0, sr0, w0;
    wb0 = n_wb; sr0 = n_sr; w0 = n_wren;
    start(); send(8'h02); send(8'h00); send(8'h10);
    for (int i = 0; i < 5; i++) bit_io(1'b1, b, e);
    stop();
    chk("R12 partial write dropped", n_wb, wb0);
    start(); send(8'h01);
    for (int i = 0; i < 3; i++) bit_io(1'b1, b, e);
    stop();
    chk("R12 partial status write dropped", n_sr, sr0);
    start();
    for (int i = 0; i < 6; i++) bit_io(1'b0, b, e);
    stop();
    start(); send(8'h06); stop();
    chk("R12 decode after abort", n_wren, w0 + 1);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (done == 0) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    wt(5);
    rst_n = 1'b1;
    wt(5);
    t_reset();
    t_opcodes();
    t_invalid();
    t_read(1'b0, 8'h03, 16'hFC05, 3);
    t_read(1'b1, 8'h0B, 16'h0123, 2);
    t_read(1'b0, 8'h03, 16'h03FE, 4);
    t_rdsr();
    t_write();
    t_wrsr();
    t_busy();
    t_hold();
    t_abort();
    done = 1;
    summary();
    $finish;
  end
endmodule